// File: doc/BRIEF.md
# Serial Clock Baud Rate Generator

This block produces the serial clock for a synchronous serial master. It can drive a two-wire bus or a four-wire shift interface. An 8-bit reload value sets the rate. A write strobe on the transmit buffer starts the generator. From then on an internal down-counter steps once every two system clocks. Each time it expires, the generator toggles the serial clock, pulses a rollover strobe for one cycle and reloads itself. Two reloads happen per serial clock period, so the output period is 4×(N+1) system clocks.

When the surrounding shift logic signals that the transfer is done, counting halts. The clock output keeps whatever level it had at that point.

In two-wire mode the block protects the bus. A reload value below 3 is replaced by 3, and a sticky error flag is raised. A reload that is requested while another device holds the line low is deferred until the line reads high, which gives clock stretching. In four-wire mode every reload value is used as given, and requested reloads take effect at once.

Top module: `sclkRateGen`

## Requirements
- R1: After synchronous active-high reset, sclOut is at the idle level (high by default), rollover and cfgError are low, and the generator stays stopped: no rollover and no sclOut change occur until a buffer write.
- R2: A buffer write at clock edge E loads the counter with the reload value N. The first sclOut toggle, together with its rollover pulse, appears after edge E+2(N+1).
- R3: While running, sclOut toggles every 2(N+1) system clocks, for a full period of 4(N+1) clocks. For example, N=0x13 gives 80 clocks and N=0x27 gives 160 clocks. The reload value is sampled again at every reload.
- R4: rollover is high for exactly one cycle at each sclOut toggle, and sclOut never changes without it.
- R5: An xferDone with no buffer write in the same cycle stops the generator. Starting with that edge there is no rollover, and sclOut holds its last level until the next buffer write. If a buffer write and xferDone arrive in the same cycle, the buffer write wins and the generator runs.
- R6: In two-wire mode (twoWire=1), loading a reload value of 0, 1 or 2 sets cfgError and counts as N=3, giving a half period of 8 clocks.
- R7: In four-wire mode (twoWire=0), reload values 0, 1 and 2 are used as given (half period 2, 4 and 6 clocks), and cfgError stays low.
- R8: In four-wire mode, a reloadReq at edge E while running reloads the counter without toggling sclOut. The next toggle follows after edge E+2(N+1).
- R9: In two-wire mode, a reloadReq while sclIn is low freezes the counter: no toggle occurs while sclIn stays low. The reload is performed at the first edge R at which sclIn is high, and the next toggle follows after edge R+2(N+1).
- R10: Once set, cfgError stays high until reset, whatever the mode or later reload values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reloadVal | input | 8 | Divide value N |
| twoWire | input | 1 | 1 selects two-wire bus mode, 0 selects four-wire shift mode |
| bufWrite | input | 1 | Transmit buffer write strobe; starts counting |
| xferDone | input | 1 | Transfer finished; stops counting |
| reloadReq | input | 1 | Request an immediate counter reload |
| sclIn | input | 1 | Sensed level of the clock line (two-wire stretching) |
| sclOut | output | 1 | Generated serial clock |
| rollover | output | 1 | One-cycle pulse at each counter expiry |
| cfgError | output | 1 | Sticky flag for an invalid two-wire reload value |

## Verification
Every reload value from 3 to 12 is swept in both modes, together with the two standard rate values 0x13 and 0x27. The first-toggle latency is measured apart from the steady half period, so a wrong start alignment cannot be hidden by a correct period. The values 0 to 2 are run in both modes: the two-wire clamp gives a half period of 8 and sets the flag, while four-wire mode keeps its own short periods. Stop, stop-with-write, four-wire reload requests and a two-wire reload held back by a low line each show the difference between halting, restarting and freezing the count.

// File: rtl/sclkGenPkg.sv
package sclkGenPkg;
  typedef struct packed {
    logic load;   // reload counter from reload value (start or requested reload)
    logic dec;    // one counting step
  } brgStrobeT;
endpackage

// File: rtl/sclkRateCtrl.sv
module sclkRateCtrl
  import sclkGenPkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      twoWire,
  input  logic      bufWrite,
  input  logic      xferDone,
  input  logic      reloadReq,
  input  logic      sclIn,
  output brgStrobeT strobe
);
  logic running;
  logic phase;
  logic pending;
  logic stopNow;
  logic wantReload;
  logic lineOk;

  assign stopNow    = xferDone && !bufWrite;
  assign wantReload = running && !stopNow && (reloadReq || pending);
  assign lineOk     = !twoWire || sclIn;

  always_comb begin
    strobe.load = bufWrite || (wantReload && lineOk);
    strobe.dec  = running && !stopNow && !wantReload && !bufWrite && phase;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      phase   <= 1'b0;
      pending <= 1'b0;
    end else begin
      if (bufWrite)     running <= 1'b1;
      else if (stopNow) running <= 1'b0;
      pending <= wantReload && !lineOk;
      if (strobe.load || !running || stopNow) phase <= 1'b0;
      else if (!wantReload)                   phase <= ~phase;
    end
  end
endmodule

// File: rtl/sclkRateDatapath.sv
module sclkRateDatapath
  import sclkGenPkg::*;
#(
  parameter int   RELOAD_W     = 8,
  parameter int   MIN_TWO_WIRE = 3,
  parameter logic CLK_IDLE     = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [RELOAD_W-1:0] reloadVal,
  input  logic                twoWire,
  input  brgStrobeT           strobe,
  output logic                sclOut,
  output logic                rollover,
  output logic                cfgError
);
  localparam logic [RELOAD_W-1:0] MIN_VAL = RELOAD_W'(MIN_TWO_WIRE);

  logic [RELOAD_W-1:0] count;
  logic [RELOAD_W-1:0] effVal;
  logic                badVal;
  logic                expire;
  logic                doLoad;

  assign badVal = twoWire && (reloadVal < MIN_VAL);
  assign effVal = badVal ? MIN_VAL : reloadVal;
  assign expire = strobe.dec && (count == '0);
  assign doLoad = strobe.load || expire;

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      sclOut   <= CLK_IDLE;
      rollover <= 1'b0;
      cfgError <= 1'b0;
    end else begin
      rollover <= expire;
      if (expire) sclOut <= ~sclOut;
      if (doLoad) begin
        count <= effVal;
        if (badVal) cfgError <= 1'b1;
      end else if (strobe.dec) begin
        count <= count - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sclkRateGen.sv
module sclkRateGen
  import sclkGenPkg::*;
#(
  parameter int   RELOAD_W     = 8,
  parameter int   MIN_TWO_WIRE = 3,
  parameter logic CLK_IDLE     = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [RELOAD_W-1:0] reloadVal,
  input  logic                twoWire,
  input  logic                bufWrite,
  input  logic                xferDone,
  input  logic                reloadReq,
  input  logic                sclIn,
  output logic                sclOut,
  output logic                rollover,
  output logic                cfgError
);
  brgStrobeT strobe;

  sclkRateCtrl u_ctrl (
    .clk(clk), .rst(rst), .twoWire(twoWire), .bufWrite(bufWrite),
    .xferDone(xferDone), .reloadReq(reloadReq), .sclIn(sclIn), .strobe(strobe)
  );

  sclkRateDatapath #(
    .RELOAD_W(RELOAD_W), .MIN_TWO_WIRE(MIN_TWO_WIRE), .CLK_IDLE(CLK_IDLE)
  ) u_dp (
    .clk(clk), .rst(rst), .reloadVal(reloadVal), .twoWire(twoWire),
    .strobe(strobe), .sclOut(sclOut), .rollover(rollover), .cfgError(cfgError)
  );
endmodule

// File: rtl/sclkRateGenChk.sv
module sclkRateGenChk (
  input logic clk,
  input logic rst,
  input logic twoWire,
  input logic bufWrite,
  input logic xferDone,
  input logic sclOut,
  input logic rollover,
  input logic cfgError
);
  a_r4_toggle_has_pulse: assert property (@(posedge clk) disable iff (rst)
    !$stable(sclOut) |-> rollover);
  a_r4_pulse_has_toggle: assert property (@(posedge clk) disable iff (rst)
    rollover |-> !$stable(sclOut));
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rollover |=> !rollover);
  a_r5_stop_quiet: assert property (@(posedge clk) disable iff (rst)
    (xferDone && !bufWrite) |=> !rollover);
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
    cfgError |=> cfgError);
  a_r6_err_two_wire: assert property (@(posedge clk) disable iff (rst)
    $rose(cfgError) |-> $past(twoWire));
endmodule

bind sclkRateGen sclkRateGenChk i_chk (
  .clk(clk), .rst(rst), .twoWire(twoWire), .bufWrite(bufWrite),
  .xferDone(xferDone), .sclOut(sclOut), .rollover(rollover), .cfgError(cfgError)
);

// File: tb/test_sclkRateGen.sv
module test_sclkRateGen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] reloadVal = 8'd5;
  logic       twoWire = 1'b0;
  logic       bufWrite = 1'b0;
  logic       xferDone = 1'b0;
  logic       reloadReq = 1'b0;
  logic       sclIn = 1'b1;
  logic       sclOut, rollover, cfgError;

  int cyc = 0;
  int rollCount = 0;
  int nChecks = 0;
  int nFails = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rollover) rollCount <= rollCount + 1;

  sclkRateGen i_sclkRateGen (
    .clk(clk), .rst(rst), .reloadVal(reloadVal), .twoWire(twoWire),
    .bufWrite(bufWrite), .xferDone(xferDone), .reloadReq(reloadReq),
    .sclIn(sclIn), .sclOut(sclOut), .rollover(rollover), .cfgError(cfgError)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    bufWrite = 0; xferDone = 0; reloadReq = 0; sclIn = 1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // start at a negedge; returns cycle count recorded right after the start edge
  task automatic startRun(input int n, input bit mode, output int refCyc);
    @(negedge clk);
    reloadVal = 8'(n); twoWire = mode; bufWrite = 1'b1;
    @(negedge clk);
    bufWrite = 1'b0;
    refCyc = cyc;
  endtask

  task automatic waitRoll(input int refCyc, output int d);
    int guard = 0;
    do begin
      @(negedge clk); guard++;
    end while (!rollover && guard < 2000);
    if (!rollover) d = -1;
    else d = cyc - refCyc;
  endtask

  task automatic stopRun();
    @(negedge clk); xferDone = 1'b1;
    @(negedge clk); xferDone = 1'b0;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin : main
    int refCyc, d, lvl, rc;
    doReset();
    // R1 reset state and idle
    @(negedge clk);
    check(sclOut == 1'b1, "R1 sclOut idle", sclOut, 1);
    check(rollover == 1'b0, "R1 rollover", rollover, 0);
    check(cfgError == 1'b0, "R1 cfgError", cfgError, 0);
    rc = rollCount;
    repeat (30) @(negedge clk);
    check(rollCount == rc, "R1 stopped after reset", rollCount - rc, 0);
    check(sclOut == 1'b1, "R1 sclOut stays idle", sclOut, 1);

    // R2/R3/R4/R5 sweep in both modes
    for (int mode = 0; mode < 2; mode++) begin
      for (int k = 0; k < 12; k++) begin
        int n;
        n = (k < 10) ? (3 + k) : ((k == 10) ? 8'h13 : 8'h27);
        lvl = sclOut;
        startRun(n, 1'(mode), refCyc);
        waitRoll(refCyc, d);
        check(d == 2*n + 2, "R2 first toggle latency", d, 2*n + 2);
        check(sclOut == 1'(~lvl), "R4 toggle with rollover", sclOut, 1 - lvl);
        for (int h = 0; h < 2; h++) begin
          refCyc = cyc; lvl = sclOut;
          waitRoll(refCyc, d);
          check(d == 2*n + 2, "R3 half period", d, 2*n + 2);
          check(sclOut == 1'(~lvl), "R4 alternation", sclOut, 1 - lvl);
        end
        stopRun();
        lvl = sclOut; rc = rollCount;
        repeat (2*n + 8) @(negedge clk);
        check(rollCount == rc, "R5 no rollover after stop", rollCount - rc, 0);
        check(sclOut == 1'(lvl), "R5 level held", sclOut, lvl);
      end
    end

    // R5 buffer write wins over xferDone in same cycle
    @(negedge clk);
    reloadVal = 8'd4; twoWire = 1'b0; bufWrite = 1'b1; xferDone = 1'b1;
    @(negedge clk);
    bufWrite = 1'b0; xferDone = 1'b0; refCyc = cyc;
    waitRoll(refCyc, d);
    check(d == 10, "R5 write wins over done", d, 10);
    stopRun();

    // R6 two-wire clamp of invalid values, R10 sticky
    for (int n = 0; n < 3; n++) begin
      doReset();
      @(negedge clk);
      check(cfgError == 1'b0, "R10 cleared by reset", cfgError, 0);
      startRun(n, 1'b1, refCyc);
      check(cfgError == 1'b1, "R6 error set", cfgError, 1);
      waitRoll(refCyc, d);
      check(d == 8, "R6 clamped half period", d, 8);
      stopRun();
    end
    startRun(5, 1'b0, refCyc);
    waitRoll(refCyc, d);
    check(cfgError == 1'b1, "R10 error stays in four-wire", cfgError, 1);
    check(d == 12, "R10 valid run after error", d, 12);
    stopRun();

    // R7 four-wire accepts small values
    doReset();
    for (int n = 0; n < 3; n++) begin
      startRun(n, 1'b0, refCyc);
      waitRoll(refCyc, d);
      check(d == 2*n + 2, "R7 four-wire small value first", d, 2*n + 2);
      refCyc = cyc;
      waitRoll(refCyc, d);
      check(d == 2*n + 2, "R7 four-wire small value period", d, 2*n + 2);
      stopRun();
    end
    check(cfgError == 1'b0, "R7 no error in four-wire", cfgError, 0);

    // R8 four-wire requested reload
    startRun(6, 1'b0, refCyc);
    waitRoll(refCyc, d);
    repeat (5) @(negedge clk);
    lvl = sclOut; rc = rollCount;
    reloadReq = 1'b1;
    @(negedge clk);
    reloadReq = 1'b0; refCyc = cyc;
    check(sclOut == 1'(lvl) && rollCount == rc, "R8 no toggle on reload", sclOut, lvl);
    waitRoll(refCyc, d);
    check(d == 14, "R8 restart after reload", d, 14);
    stopRun();

    // R9 two-wire stretch
    startRun(5, 1'b1, refCyc);
    waitRoll(refCyc, d);
    repeat (3) @(negedge clk);
    sclIn = 1'b0; reloadReq = 1'b1;
    @(negedge clk);
    reloadReq = 1'b0;
    rc = rollCount; lvl = sclOut;
    repeat (40) @(negedge clk);
    check(rollCount == rc, "R9 frozen while line low", rollCount - rc, 0);
    check(sclOut == 1'(lvl), "R9 level held while low", sclOut, lvl);
    sclIn = 1'b1;
    @(negedge clk);
    refCyc = cyc;
    waitRoll(refCyc, d);
    check(d == 12, "R9 reload at release", d, 12);
    stopRun();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule